// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address to a physical address after a translation miss. It walks a two-level page table in memory. A request carries the virtual address and the root pointer of the address space. The root pointer is the only per-space state the walk needs. The walker takes the address apart into three fields. The top field indexes the outer table. The outer entry gives the base of an inner table. The middle field indexes that inner table, and the inner entry gives the physical frame. The low 12 bits of the virtual address pass through unchanged as the page offset.

Memory is reached one 32-bit word at a time through a request/response port. The two reads depend on each other, so they are issued strictly one after the other. Every table entry carries a valid flag. If a walk meets a cleared flag at either level, it ends with a fault response. That response names the level that faulted and carries no physical address. A new walk is taken only when the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: `reqReady` is high exactly when the walker is idle. A request is accepted on a clock edge where `reqValid` and `reqReady` are both high. While a memory read is being requested, `reqReady` is low.
- R2: The first memory read is at `rootBase + 4*vaddr[31:22]`, using the `rootBase` value sampled when the request is accepted.
- R3: The second memory read is at `{outer[31:12], 12'h000} + 4*vaddr[21:12]`, where `outer` is the word returned by the first read.
- R4: Bit 0 of a table entry is its valid flag. An entry with bit 0 clear is invalid, whatever its other bits hold.
- R5: On a successful walk, the response has `respFault` = 0, `respLevel` = 0 and `respPaddr` = `{inner[31:12], vaddr[11:0]}`, where `inner` is the word returned by the second read.
- R6: If the outer entry is invalid, the walk issues no second read. It responds with `respFault` = 1, `respLevel` = 0 and `respPaddr` = 0.
- R7: If the inner entry is invalid, the walk responds with `respFault` = 1, `respLevel` = 1 and `respPaddr` = 0. `respLevel` is 0 on every response that is not a fault.
- R8: A successful walk issues exactly two memory reads. `memReqValid` stays high, with `memReqAddr` unchanged, until a cycle in which `memReqReady` is high.
- R9: After reset, `reqReady` = 1, `memReqValid` = 0 and `respValid` = 0. Each response is a `respValid` pulse lasting one cycle.
- R10: Values on `reqValid`, `reqVaddr` and `rootBase` while a walk is in progress have no effect on that walk's memory reads or its response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle, request can be taken |
| reqVaddr | input | 32 | Virtual address to translate |
| rootBase | input | 32 | Byte address of the outer table |
| memReqValid | output | 1 | Memory read request |
| memReqReady | input | 1 | Memory accepts the read this cycle |
| memReqAddr | output | 32 | Byte address of the entry to read |
| memRspValid | input | 1 | Read data returned this cycle |
| memRspData | input | 32 | Returned table entry |
| respValid | output | 1 | Walk result, one-cycle pulse |
| respFault | output | 1 | Walk ended on an invalid entry |
| respLevel | output | 1 | Faulting level: 0 outer, 1 inner |
| respPaddr | output | 32 | Translated physical address, 0 on fault |

## Verification
The bench aims at the following corner cases:
- Index extremes (0 and 1023 in both fields) and an offset of 0xFFF. A wrong field slice or a missing times-four scaling would send the reads to the wrong words.
- A root pointer that is not page aligned. If the walker concatenates instead of adding, that address comes out wrong.
- Invalid entries at both levels, including one with all other bits set. A walker that tests the wrong bit would translate instead of faulting. A walker that keeps going after an outer fault would issue a stray second read.
- A request held high with a different address in the middle of a walk. A walker that does not gate acceptance on idle would latch the new address and return a wrong frame.
- Random read back-pressure and random response latency. These expose a walker that drops a read or changes its address before the read is accepted.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;
  localparam int VA_W      = 32;
  localparam int PA_W      = 32;
  localparam int OFF_W     = 12;
  localparam int IDX_W     = (VA_W - OFF_W) / 2;
  localparam int PTE_W     = 32;
  localparam int PTE_BYTES = 4;
  localparam int PTE_SHIFT = $clog2(PTE_BYTES);
  localparam int PFN_W     = PA_W - OFF_W;
  localparam int VALID_BIT = 0;

  typedef enum logic [2:0] {
    IDLE, READ_L1, WAIT_L1, READ_L2, WAIT_L2, DONE, FAULT
  } walkState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic loadOuter;
    logic loadInner;
    logic selInner;
    logic emitPaddr;
  } dpCtrl_t;
endpackage

// File: rtl/pt_walk_ctrl.sv
module pt_walk_ctrl
  import pt_walk_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    memReqReady,
  input  logic    memRspValid,
  input  logic    entryValid,
  output logic    reqReady,
  output logic    memReqValid,
  output logic    respValid,
  output logic    respFault,
  output logic    respLevel,
  output dpCtrl_t dpCtrl
);
  walkState_e state, stateNext;
  logic faultLevelQ, faultLevelNext;

  always_comb begin
    stateNext      = state;
    faultLevelNext = faultLevelQ;
    unique case (state)
      IDLE:    if (reqValid) stateNext = READ_L1;
      READ_L1: if (memReqReady) stateNext = WAIT_L1;
      WAIT_L1: if (memRspValid) begin
        if (entryValid) stateNext = READ_L2;
        else begin
          stateNext      = FAULT;
          faultLevelNext = 1'b0;
        end
      end
      READ_L2: if (memReqReady) stateNext = WAIT_L2;
      WAIT_L2: if (memRspValid) begin
        if (entryValid) stateNext = DONE;
        else begin
          stateNext      = FAULT;
          faultLevelNext = 1'b1;
        end
      end
      DONE:    stateNext = IDLE;
      FAULT:   stateNext = IDLE;
      default: stateNext = IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= IDLE;
      faultLevelQ <= 1'b0;
    end else begin
      state       <= stateNext;
      faultLevelQ <= faultLevelNext;
    end
  end

  assign reqReady    = (state == IDLE);
  assign memReqValid = (state == READ_L1) || (state == READ_L2);
  assign respValid   = (state == DONE) || (state == FAULT);
  assign respFault   = (state == FAULT);
  assign respLevel   = (state == FAULT) && faultLevelQ;

  always_comb begin
    dpCtrl.loadReq   = (state == IDLE) && reqValid;
    dpCtrl.loadOuter = (state == WAIT_L1) && memRspValid;
    dpCtrl.loadInner = (state == WAIT_L2) && memRspValid;
    dpCtrl.selInner  = (state == READ_L2) || (state == WAIT_L2);
    dpCtrl.emitPaddr = (state == DONE);
  end
endmodule

// File: rtl/pt_walk_dp.sv
module pt_walk_dp
  import pt_walk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          dpCtrl,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [PA_W-1:0]  rootBase,
  input  logic [PTE_W-1:0] memRspData,
  output logic [PA_W-1:0]  memReqAddr,
  output logic             entryValid,
  output logic [PA_W-1:0]  respPaddr
);
  logic [VA_W-1:0]  vaddrQ;
  logic [PA_W-1:0]  rootQ;
  logic [PFN_W-1:0] outerPfnQ;
  logic [PFN_W-1:0] framePfnQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaddrQ    <= '0;
      rootQ     <= '0;
      outerPfnQ <= '0;
      framePfnQ <= '0;
    end else begin
      if (dpCtrl.loadReq) begin
        vaddrQ <= reqVaddr;
        rootQ  <= rootBase;
      end
      if (dpCtrl.loadOuter) outerPfnQ <= memRspData[PTE_W-1 -: PFN_W];
      if (dpCtrl.loadInner) framePfnQ <= memRspData[PTE_W-1 -: PFN_W];
    end
  end

  logic [IDX_W-1:0] outerIdx, innerIdx;
  logic [PA_W-1:0]  outerAddr, innerAddr;

  assign outerIdx  = vaddrQ[VA_W-1 -: IDX_W];
  assign innerIdx  = vaddrQ[OFF_W +: IDX_W];
  assign outerAddr = rootQ + (PA_W'(outerIdx) << PTE_SHIFT);
  assign innerAddr = {outerPfnQ, {OFF_W{1'b0}}} + (PA_W'(innerIdx) << PTE_SHIFT);

  assign memReqAddr = dpCtrl.selInner ? innerAddr : outerAddr;
  assign entryValid = memRspData[VALID_BIT];
  assign respPaddr  = dpCtrl.emitPaddr ? {framePfnQ, vaddrQ[OFF_W-1:0]} : '0;

  // attribute bits between flag and frame number are not interpreted
  logic unusedPteBits;
  assign unusedPteBits = ^memRspData[OFF_W-1:VALID_BIT+1];
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walk_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [PA_W-1:0]  rootBase,
  output logic             memReqValid,
  input  logic             memReqReady,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRspValid,
  input  logic [PTE_W-1:0] memRspData,
  output logic             respValid,
  output logic             respFault,
  output logic             respLevel,
  output logic [PA_W-1:0]  respPaddr
);
  dpCtrl_t dpCtrl;
  logic    entryValid;

  pt_walk_ctrl i_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .memReqReady (memReqReady),
    .memRspValid (memRspValid),
    .entryValid  (entryValid),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .respValid   (respValid),
    .respFault   (respFault),
    .respLevel   (respLevel),
    .dpCtrl      (dpCtrl)
  );

  pt_walk_dp i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dpCtrl     (dpCtrl),
    .reqVaddr   (reqVaddr),
    .rootBase   (rootBase),
    .memRspData (memRspData),
    .memReqAddr (memReqAddr),
    .entryValid (entryValid),
    .respPaddr  (respPaddr)
  );
endmodule

// File: rtl/pt_walk_chk.sv
module pt_walk_chk
  import pt_walk_pkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            reqReady,
  input logic            memReqValid,
  input logic            memReqReady,
  input logic [PA_W-1:0] memReqAddr,
  input logic            respValid,
  input logic            respFault,
  input logic            respLevel,
  input logic [PA_W-1:0] respPaddr
);
  // R1
  busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  // R1
  resp_not_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> !reqReady);

  // R8
  hold_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    respValid |=> !respValid);

  // R6
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respFault) |-> (respPaddr == '0));

  // R7
  level_on_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respFault) |-> !respLevel);
endmodule

bind pt_walker pt_walk_chk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqReady    (reqReady),
  .memReqValid (memReqValid),
  .memReqReady (memReqReady),
  .memReqAddr  (memReqAddr),
  .respValid   (respValid),
  .respFault   (respFault),
  .respLevel   (respLevel),
  .respPaddr   (respPaddr)
);

// File: tb/test_pt_walker.sv
module test_pt_walker;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [31:0] reqVaddr = '0;
  logic [31:0] rootBase = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [31:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [31:0] memRspData = '0;
  logic        respValid;
  logic        respFault;
  logic        respLevel;
  logic [31:0] respPaddr;

  always #4 clk = ~clk;

  pt_walker i_pt_walker (.*);

  typedef struct packed {
    logic        fault;
    logic        level;
    logic [31:0] paddr;
  } expect_t;

  logic [31:0] memModel [logic [31:0]];
  expect_t     expQ[$];
  string       tagQ[$];
  logic [31:0] addrQ[$];
  int          checks = 0;
  int          fails = 0;
  int          respCount = 0;
  bit          ended = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return memModel.exists(a) ? memModel[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [33:0] act, input logic [33:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finishUp();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  // memory responder: random back-pressure and latency, checks read addresses
  initial begin
    bit          pend = 0;
    int          lat = 0;
    logic [31:0] pendAddr = '0;
    forever begin
      @(negedge clk);
      memRspValid = 1'b0;
      if (pend) begin
        if (lat == 0) begin
          memRspValid = 1'b1;
          memRspData  = rd(pendAddr);
          pend = 0;
        end else lat--;
      end
      memReqReady = ($urandom_range(0, 3) != 0);
      if (rstN && memReqValid && memReqReady) begin
        if (addrQ.size() == 0) begin
          check(0, "R6/R8", "unexpected memory read", {2'b0, memReqAddr}, 34'h0);
        end else begin
          logic [31:0] e;
          e = addrQ.pop_front();
          // R2 / R3: read address
          check(memReqAddr == e, "R2/R3", "read address", {2'b0, memReqAddr}, {2'b0, e});
        end
        pendAddr = memReqAddr;
        pend = 1;
        lat = $urandom_range(0, 2);
      end
    end
  end

  // monitor: pops scoreboard
  initial begin
    bit prevResp = 0;
    forever begin
      @(negedge clk);
      if (respValid) begin
        check(!prevResp, "R9", "response pulse longer than one cycle", 34'h1, 34'h0);
        if (expQ.size() == 0) begin
          check(0, "R5", "response with nothing expected", {respFault, respLevel, respPaddr}, 34'h0);
        end else begin
          expect_t e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          check({respFault, respLevel, respPaddr} == e, t, "fault/level/paddr",
                {respFault, respLevel, respPaddr}, e);
          check(addrQ.size() == 0, "R8", "reads left unissued", 34'(addrQ.size()), 34'h0);
        end
        respCount++;
      end
      prevResp = respValid;
    end
  end

  // driver: computes expectation from the table contents, then issues the request
  task automatic walk(input logic [31:0] va, input logic [31:0] root,
                      input string tag, input bit poke);
    expect_t     e;
    logic [31:0] a1, a2, e1, e2;
    int          start;
    a1 = root + {20'h0, va[31:22], 2'b00};
    e1 = rd(a1);
    addrQ.push_back(a1);
    if (!e1[0]) e = '{fault: 1'b1, level: 1'b0, paddr: 32'h0};
    else begin
      a2 = {e1[31:12], 12'h000} + {20'h0, va[21:12], 2'b00};
      e2 = rd(a2);
      addrQ.push_back(a2);
      if (!e2[0]) e = '{fault: 1'b1, level: 1'b1, paddr: 32'h0};
      else e = '{fault: 1'b0, level: 1'b0, paddr: {e2[31:12], va[11:0]}};
    end
    expQ.push_back(e);
    tagQ.push_back(tag);
    start = respCount;
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqVaddr = va;
    rootBase = root;
    @(negedge clk);
    // R1: busy once accepted
    check(!reqReady, "R1", "reqReady after accept", {33'h0, reqReady}, 34'h0);
    if (poke) begin
      // R10: new values while busy
      reqVaddr = ~va;
      rootBase = root + 32'h40;
      repeat (3) @(negedge clk);
    end
    reqValid = 1'b0;
    while (respCount == start) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "R9", "watchdog expired", 34'h0, 34'h1);
    finishUp();
  end

  initial begin
    logic [31:0] root;
    root = 32'h0001_0000;
    memModel[root + 32'd0]         = 32'h0002_0001;  // outer 0 -> inner table 0x20000
    memModel[root + 32'd4092]      = 32'h0003_0001;  // outer 1023 -> 0x30000
    memModel[root + 32'd12]        = 32'hFFFF_FFFE;  // outer 3: all set but flag
    memModel[32'h0002_0000]        = 32'h000A_B001;
    memModel[32'h0002_0000 + 20]   = 32'h0123_4001;
    memModel[32'h0002_0000 + 4092] = 32'hFFFF_F001;
    memModel[32'h0002_0000 + 28]   = 32'h0777_7FFE;  // inner 7 invalid
    memModel[32'h0003_0004]        = 32'h0C0D_E001;

    repeat (4) @(negedge clk);
    // R9: reset values
    check(reqReady === 1'b1, "R9", "reqReady in reset", {33'h0, reqReady}, 34'h1);
    check(memReqValid === 1'b0, "R9", "memReqValid in reset", {33'h0, memReqValid}, 34'h0);
    check(respValid === 1'b0, "R9", "respValid in reset", {33'h0, respValid}, 34'h0);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady === 1'b1 && respValid === 1'b0, "R9", "idle after reset",
          {32'h0, reqReady, respValid}, 34'h2);

    walk(32'h0000_0123, root, "R5", 0);          // both indices 0
    walk(32'h0000_5FFF, root, "R5", 0);          // offset all ones
    walk(32'h003F_F000, root, "R3", 0);          // inner index 1023
    walk(32'hFFC0_1456, root, "R2", 0);          // outer index 1023
    walk(32'h0080_0ABC, root, "R6", 0);          // outer entry absent
    walk(32'h00C0_0000, root, "R4", 0);          // outer flag clear, other bits set
    walk(32'h0000_7010, root, "R7", 0);          // inner entry invalid
    walk(32'h0040_0321, 32'h0000_FFFC, "R2", 0); // unaligned root, outer idx 1
    walk(32'h0000_0123, root, "R10", 1);         // request changes mid-walk
    walk(32'h0000_7FFF, root, "R7", 1);
    walk(32'h0000_5000, root, "R8", 0);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R8", "responses outstanding", 34'(expQ.size()), 34'h0);
    finishUp();
  end
endmodule